// File: doc/BRIEF.md
# Oversampled Serial Link Aligner

This block sits behind a deserializer front end on one fast serial channel from a digital focal-plane array. Every clock it takes one parallel word holding four samples of a single bit period. The delay of the link is unknown but fixed, so the block cannot know where a bit starts or where a packet starts. It finds both from one recurring 16-bit sync word. Each of the four sample phases is treated as its own candidate bit stream, and the phases that see the sync word cleanly are scored as good. The centre of the widest group of adjacent good phases becomes the sampling point. The same detection sets the packet boundary.

After the sync word has appeared at the expected spacing often enough, the block declares lock. It then delivers each payload word on a parallel bus with a valid strobe, and it marks the first word of every packet. Sync words that go missing are tolerated once. A second one in a row sends the block back to searching.

Top module: `oal_link_aligner`

## Requirements
- R1: Each clock, `i_samples` carries four samples of one bit period, bit 0 being the earliest in time. Payload is recovered correctly for any fixed sample delay; delays of 0 to 7 samples are exercised.
- R2: A packet is the sync word 16'hFE6B, sent MSB first, followed by four 16-bit payload words, also MSB first. The sync word marks where a packet begins.
- R3: A phase is good when its own sample stream completes the sync word, in the same cycle as the first detection or in the cycle after it. The chosen phase is the centre, start + (length-1)/2 modulo 4, of the widest run of adjacent good phases, counted circularly. On a tie the lowest start wins. The chosen phase is reported on `o_phase`.
- R4: Lock is declared once the sync word has been found at the same packet spacing three times in a row, the first detection included. The first word delivered is the first payload word of the packet whose sync word completed the third sighting.
- R5: If the sync word is missing at the expected place before lock is declared, the search restarts from scratch.
- R6: While locked, a single missing sync word does not drop lock, and payload delivery continues without a gap.
- R7: While locked, two missing sync words in a row drop lock. Delivery stops, and lock is only regained through a fresh search and three new sightings.
- R8: `o_valid` is high only while locked, for exactly one cycle per payload word. `o_sop` is high only together with the first payload word of a packet.
- R9: One clock edge with `rst_n` low clears `o_valid` and `o_sop`, sets `o_phase` to 0, and restarts the search.
- R10: `o_phase` does not change while lock is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock of the deserializer |
| rst_n | input | 1 | Synchronous reset, active low |
| i_samples | input | 4 | Samples of one bit period, bit 0 earliest |
| o_data | output | 16 | Aligned payload word, first received bit in the MSB |
| o_valid | output | 1 | One-cycle strobe for `o_data` while locked |
| o_sop | output | 1 | Marks the first payload word of a packet |
| o_phase | output | 2 | Sampling phase currently in use |

## Verification
The stimulus is built from sample delays that put the bit edge on every phase, including delays longer than one bit. Some streams are clean, which makes all four phases good. Others have one corrupted sample at the bit edge, which leaves a run of three good phases. The rest also corrupt the last sample of each bit, which leaves a run of two. The phase each case must pick differs, so a wrong centre rule or a wrong circular wrap shows up on `o_phase`. Streams with sync words removed at chosen packets separate the single-miss tolerance from the double-miss drop and from a restart during confirmation, because each one moves the first payload word that comes out.

// File: rtl/oal_pkg.sv
// Package: shared types for the oversampled link aligner.
// Assumes: nothing; holds only the alignment state encoding.
package oal_pkg;

    typedef enum logic [1:0] {
        ST_SEARCH  = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2
    } oal_state_e;

endpackage

// File: rtl/oal_phase_score.sv
// Module: oal_phase_score
// Treats each sample phase as its own bit stream. It flags the phases whose
// last SYNC_W bits equal the sync word, both now and one cycle earlier, and
// keeps a two-deep history of the raw samples for the selected-stream tap.
// Assumes: one bit period per input word, sample 0 earliest.
module oal_phase_score #(
    parameter int                OVS      = 4,
    parameter int                SYNC_W   = 16,
    parameter logic [SYNC_W-1:0] SYNC_PAT = 16'hFE6B
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OVS-1:0] samples,
    output logic [OVS-1:0] hit_now,
    output logic [OVS-1:0] hit_prev,
    output logic [OVS-1:0] samp_d1,
    output logic [OVS-1:0] samp_d2
);

    genvar p;
    generate
        for (p = 0; p < OVS; p++) begin : g_phase
            logic [SYNC_W-1:0] hist_q;

            // Shift this phase's samples into its own history register.
            always_ff @(posedge clk) begin
                if (!rst_n) hist_q <= '0;
                else        hist_q <= {hist_q[SYNC_W-2:0], samples[p]};
            end

            assign hit_now[p] = (hist_q == SYNC_PAT);
        end
    endgenerate

    // Delay the hit flags and raw samples for the two-cycle detection window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_prev <= '0;
            samp_d1  <= '0;
            samp_d2  <= '0;
        end else begin
            hit_prev <= hit_now;
            samp_d1  <= samples;
            samp_d2  <= samp_d1;
        end
    end

endmodule

// File: rtl/oal_phase_pick.sv
// Module: oal_phase_pick
// Finds the widest circular run of set bits in the phase mask and returns
// its centre. Ties go to the lowest start index.
// Assumes: purely combinational, OVS small.
module oal_phase_pick #(
    parameter int OVS  = 4,
    parameter int PH_W = 2
) (
    input  logic [OVS-1:0]  good_mask,
    output logic [PH_W-1:0] centre
);

    // Search run lengths from longest to shortest; first full run wins.
    always_comb begin
        logic found;
        logic ok;
        found  = 1'b0;
        centre = '0;
        for (int len = OVS; len >= 1; len--) begin
            for (int s = 0; s < OVS; s++) begin
                ok = 1'b1;
                for (int i = 0; i < len; i++) begin
                    if (!good_mask[(s + i) % OVS]) ok = 1'b0;
                end
                if (ok && !found) begin
                    found  = 1'b1;
                    centre = PH_W'((s + (len - 1) / 2) % OVS);
                end
            end
        end
    end

endmodule

// File: rtl/oal_frame_track.sv
// Module: oal_frame_track
// Runs the search/confirm/lock sequence, follows the chosen phase with a
// bit counter over a whole packet, checks the sync word at each expected
// slot, and assembles payload words.
// Assumes: packet = SYNC_W sync bits then PAY_WORDS words of WORD_W bits,
// WORD_W <= SYNC_W, LOCK_HITS >= 2, DROP_MISSES >= 1.
module oal_frame_track
    import oal_pkg::*;
#(
    parameter int                OVS         = 4,
    parameter int                PH_W        = 2,
    parameter int                SYNC_W      = 16,
    parameter logic [SYNC_W-1:0] SYNC_PAT    = 16'hFE6B,
    parameter int                WORD_W      = 16,
    parameter int                PAY_WORDS   = 4,
    parameter int                LOCK_HITS   = 3,
    parameter int                DROP_MISSES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OVS-1:0]    hit_prev,
    input  logic [OVS-1:0]    samp_d1,
    input  logic [OVS-1:0]    samp_d2,
    input  logic [PH_W-1:0]   pick,
    output logic [WORD_W-1:0] o_data,
    output logic              o_valid,
    output logic              o_sop,
    output logic [PH_W-1:0]   o_phase,
    output logic              locked,
    output logic              confirming
);

    localparam int PAY_BITS = WORD_W * PAY_WORDS;
    localparam int PKT_BITS = PAY_BITS + SYNC_W;
    localparam int POS_W    = $clog2(PKT_BITS);
    localparam int CONF_W   = $clog2(LOCK_HITS + 1);
    localparam int MISS_W   = $clog2(DROP_MISSES + 1);

    oal_state_e        state_q;
    logic [PH_W-1:0]   phase_q;
    logic              late_tap_q;
    logic [POS_W-1:0]  pos_q;
    logic [CONF_W-1:0] conf_q;
    logic [MISS_W-1:0] miss_q;
    logic [SYNC_W-1:0] win_q;

    logic              sel_bit;
    logic [SYNC_W-1:0] win_next;
    logic              sync_ok;
    logic              at_end;
    logic              word_end;
    logic              first_word;

    assign sel_bit    = late_tap_q ? samp_d2[phase_q] : samp_d1[phase_q];
    assign win_next   = {win_q[SYNC_W-2:0], sel_bit};
    assign sync_ok    = (win_next == SYNC_PAT);
    assign at_end     = (pos_q == POS_W'(PKT_BITS - 1));
    assign word_end   = (int'(pos_q) < PAY_BITS) && ((int'(pos_q) % WORD_W) == WORD_W - 1);
    assign first_word = (pos_q == POS_W'(WORD_W - 1));

    assign locked     = (state_q == ST_LOCKED);
    assign confirming = (state_q == ST_CONFIRM);
    assign o_phase    = phase_q;

    // Alignment state machine: pick the phase, confirm the spacing, guard the lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_SEARCH;
            phase_q    <= '0;
            late_tap_q <= 1'b0;
            pos_q      <= '0;
            conf_q     <= '0;
            miss_q     <= '0;
        end else begin
            case (state_q)
                ST_SEARCH: begin
                    if (|hit_prev) begin
                        phase_q    <= pick;
                        late_tap_q <= hit_prev[pick];
                        pos_q      <= '0;
                        conf_q     <= CONF_W'(1);
                        miss_q     <= '0;
                        state_q    <= ST_CONFIRM;
                    end
                end
                ST_CONFIRM: begin
                    pos_q <= at_end ? '0 : pos_q + 1'b1;
                    if (at_end) begin
                        if (!sync_ok) begin
                            state_q <= ST_SEARCH;
                        end else if (conf_q + 1'b1 == CONF_W'(LOCK_HITS)) begin
                            state_q <= ST_LOCKED;
                            miss_q  <= '0;
                        end else begin
                            conf_q <= conf_q + 1'b1;
                        end
                    end
                end
                ST_LOCKED: begin
                    pos_q <= at_end ? '0 : pos_q + 1'b1;
                    if (at_end) begin
                        if (sync_ok) begin
                            miss_q <= '0;
                        end else if (miss_q + 1'b1 == MISS_W'(DROP_MISSES)) begin
                            state_q <= ST_SEARCH;
                        end else begin
                            miss_q <= miss_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_SEARCH;
            endcase
        end
    end

    // Shift the selected stream into the sync/word window.
    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_next;
    end

    // Register finished payload words and their strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_data  <= '0;
            o_valid <= 1'b0;
            o_sop   <= 1'b0;
        end else begin
            o_valid <= locked && word_end;
            o_sop   <= locked && first_word;
            if (locked && word_end) o_data <= win_next[WORD_W-1:0];
        end
    end

endmodule

// File: rtl/oal_link_aligner.sv
// Module: oal_link_aligner (top)
// Aligns one oversampled serial channel: scores the sample phases on the
// sync word, picks the centre phase, tracks packets and emits payload words.
// Assumes: the deserializer delivers OVS samples of one bit per clock and
// the link delay stays fixed while locked.
module oal_link_aligner #(
    parameter int                OVS         = 4,
    parameter int                SYNC_W      = 16,
    parameter logic [SYNC_W-1:0] SYNC_PAT    = 16'hFE6B,
    parameter int                WORD_W      = 16,
    parameter int                PAY_WORDS   = 4,
    parameter int                LOCK_HITS   = 3,
    parameter int                DROP_MISSES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [OVS-1:0]             i_samples,
    output logic [WORD_W-1:0]          o_data,
    output logic                       o_valid,
    output logic                       o_sop,
    output logic [$clog2(OVS)-1:0]     o_phase
);

    localparam int PH_W = $clog2(OVS);

    logic [OVS-1:0]  hit_now;
    logic [OVS-1:0]  hit_prev;
    logic [OVS-1:0]  samp_d1;
    logic [OVS-1:0]  samp_d2;
    logic [PH_W-1:0] pick;
    logic            trk_locked;
    logic            trk_confirm;

    oal_phase_score #(
        .OVS(OVS), .SYNC_W(SYNC_W), .SYNC_PAT(SYNC_PAT)
    ) u_score (
        .clk(clk), .rst_n(rst_n), .samples(i_samples),
        .hit_now(hit_now), .hit_prev(hit_prev),
        .samp_d1(samp_d1), .samp_d2(samp_d2)
    );

    oal_phase_pick #(
        .OVS(OVS), .PH_W(PH_W)
    ) u_pick (
        .good_mask(hit_now | hit_prev), .centre(pick)
    );

    oal_frame_track #(
        .OVS(OVS), .PH_W(PH_W), .SYNC_W(SYNC_W), .SYNC_PAT(SYNC_PAT),
        .WORD_W(WORD_W), .PAY_WORDS(PAY_WORDS),
        .LOCK_HITS(LOCK_HITS), .DROP_MISSES(DROP_MISSES)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .hit_prev(hit_prev),
        .samp_d1(samp_d1), .samp_d2(samp_d2), .pick(pick),
        .o_data(o_data), .o_valid(o_valid), .o_sop(o_sop), .o_phase(o_phase),
        .locked(trk_locked), .confirming(trk_confirm)
    );

endmodule

// File: rtl/oal_link_aligner_chk.sv
// Module: oal_link_aligner_chk
// Temporal checks on the aligner outputs and its lock state, bound to the top.
// Assumes: synchronous active-low reset.
module oal_link_aligner_chk #(
    parameter int PH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            o_valid,
    input logic            o_sop,
    input logic [PH_W-1:0] o_phase,
    input logic            locked,
    input logic            confirming
);

    AST_SOP_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        o_sop |-> o_valid);                                        // R8
    AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> $past(locked));                                // R8
    AST_WORD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |=> !o_valid);                                     // R8
    AST_LOCK_AFTER_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(confirming));                      // R4
    AST_PHASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(o_phase));           // R10
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!o_valid && !o_sop));                          // R9

endmodule

bind oal_link_aligner oal_link_aligner_chk #(.PH_W(PH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .o_valid(o_valid), .o_sop(o_sop),
    .o_phase(o_phase), .locked(trk_locked), .confirming(trk_confirm)
);

// File: tb/tb_oal_link_aligner.sv
// Bench for oal_link_aligner: a vector table of delay / jitter cases with the
// expected phase, then directed runs for missing sync words and reset.
module tb_oal_link_aligner;

    localparam int          CLK_PERIOD = 10;
    localparam int          OVS        = 4;
    localparam int          SYNC_W     = 16;
    localparam logic [15:0] SYNC       = 16'hFE6B;
    localparam int          WORD_W     = 16;
    localparam int          PAYW       = 4;
    localparam int          PKT        = SYNC_W + WORD_W * PAYW;
    localparam int          LEAD       = 20;
    localparam int          NVEC       = 8;
    // {sample delay, jitter mode, expected phase}; mode 1 spoils the edge
    // sample, mode 2 also spoils the last sample of each bit.
    localparam int VEC [NVEC][3] = '{
        '{0, 0, 1}, '{1, 0, 1}, '{2, 1, 0}, '{3, 1, 1},
        '{5, 1, 3}, '{6, 2, 3}, '{1, 2, 2}, '{7, 0, 1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  i_samples = '0;
    logic [15:0] o_data;
    logic        o_valid;
    logic        o_sop;
    logic [1:0]  o_phase;

    int n_checks = 0;
    int n_fail   = 0;
    int cur_bad_a = -1;
    int cur_bad_b = -1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    oal_link_aligner dut (
        .clk(clk), .rst_n(rst_n), .i_samples(i_samples),
        .o_data(o_data), .o_valid(o_valid), .o_sop(o_sop), .o_phase(o_phase)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] word_val(input int pk, input int w);
        return 16'((pk * 37 + w * 11 + 5) % 128);
    endfunction

    // Transmitted bit n: idle zeros, then packets of sync + payload, MSB first.
    function automatic logic bit_at(input int n);
        int m, pk, off, w, b;
        logic [15:0] v;
        if (n < LEAD) return 1'b0;
        m   = n - LEAD;
        pk  = m / PKT;
        off = m % PKT;
        if (off < SYNC_W) begin
            if (pk == cur_bad_a || pk == cur_bad_b) return 1'b0;
            return SYNC[15 - off];
        end
        w = (off - SYNC_W) / WORD_W;
        b = (off - SYNC_W) % WORD_W;
        v = word_val(pk, w);
        return v[15 - b];
    endfunction

    function automatic logic sample_at(input int s, input int dly, input int mode);
        int q;
        logic v;
        if (s < dly) return 1'b0;
        q = s - dly;
        v = bit_at(q / OVS);
        if (mode >= 1 && (q % OVS) == 0) v = ~v;
        if (mode == 2 && (q % OVS) == OVS - 1) v = ~v;
        return v;
    endfunction

    // R9: reset, then confirm the outputs are cleared.
    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        i_samples = '0;
        repeat (3) @(negedge clk);
        chk(!o_valid, "R9", {tag, " valid after reset"}, o_valid, 0);
        chk(!o_sop, "R9", {tag, " sop after reset"}, o_sop, 0);
        chk(o_phase == 2'd0, "R9", {tag, " phase after reset"}, o_phase, 0);
        rst_n = 1'b1;
    endtask

    // Stream a case and compare each delivered word to the expected sequence.
    task automatic run_case(input int dly, input int mode, input int exp_ph,
                            input int first_pkt, input int skip_from, input int skip_to,
                            input int nwords, input int bad_a, input int bad_b,
                            input string tag);
        int exp_pkt, exp_w, seen, limit;
        bit first;
        cur_bad_a = bad_a;
        cur_bad_b = bad_b;
        do_reset(tag);
        exp_pkt = first_pkt;
        exp_w   = 0;
        seen    = 0;
        first   = 1'b1;
        limit   = PKT * (skip_to + first_pkt + nwords / PAYW + 6) + 200;
        for (int t = 0; t < limit && seen < nwords; t++) begin
            if (o_valid) begin
                if (first) begin
                    chk(o_phase == 2'(exp_ph), "R3", {tag, " chosen phase"}, o_phase, exp_ph);
                    first = 1'b0;
                end
                chk(o_data == word_val(exp_pkt, exp_w), "R1 R2 R4 R6 R7",
                    {tag, " payload word"}, o_data, word_val(exp_pkt, exp_w));
                chk(o_sop == (exp_w == 0), "R8", {tag, " start marker"}, o_sop, exp_w == 0);
                seen++;
                exp_w++;
                if (exp_w == PAYW) begin
                    exp_w = 0;
                    exp_pkt = (exp_pkt == skip_from) ? skip_to : exp_pkt + 1;
                end
            end
            for (int p = 0; p < OVS; p++) i_samples[p] = sample_at(OVS * t + p, dly, mode);
            @(negedge clk);
        end
        chk(seen == nwords, "R4", {tag, " word count"}, seen, nwords);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // Table: R1 delays, R3 phase choice, R4 first word of packet 2.
        for (int v = 0; v < NVEC; v++) begin
            run_case(VEC[v][0], VEC[v][1], VEC[v][2], 2, -1, 0, 8, -1, -1,
                     $sformatf("vec%0d", v));
        end
        // R6: one missing sync while locked keeps delivery continuous.
        run_case(2, 0, 1, 2, -1, 0, 20, 4, -1, "r6_single_miss");
        // R7: two missing syncs drop lock; next words come from packet 8.
        run_case(3, 1, 1, 2, 4, 8, 20, 4, 5, "r7_double_miss");
        // R5: missing sync during confirmation restarts; lock from packets 2..4.
        run_case(1, 1, 3, 4, -1, 0, 8, 1, -1, "r5_confirm_restart");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule